// File: doc/BRIEF.md
# Shock-Proof Frame Buffer Controller

This block keeps a circular buffer of raw disc symbols in an external single-port memory. It sits between the acquisition front end and the error corrector. Incoming symbols arrive in bursts whose rate changes with disc jitter and spindle speed. Each one is stored uncorrected, together with its validity flag, and symbols are committed to the reader only in whole frames. The reader drains the buffer at a fixed rate set by a cycle divider. When a mechanical shock interrupts the incoming stream, playback continues from the stored reserve.

The controller has three parts. A write-pointer unit accepts symbols and holds one pending word. A read-pointer unit issues reads at the fixed rate. An arbiter lets a read take the memory port whenever both sides want it in the same cycle. The block also reports the committed fill level and produces a speed request with hysteresis. The request asks for above-normal disc speed until the reserve reaches an upper mark, and asks for it again only when the reserve falls below a lower mark.

The input is a valid/ready stream. A symbol is taken on every edge where `in_valid` and `in_ready` are both high. The source must hold its data stable while `in_valid` is high and `in_ready` is low. The output has no back-pressure, because it runs at the fixed read rate: `out_valid` is a one-cycle strobe and the consumer must take the symbol in that cycle.

Top module: `shock_buf_ctrl`

## Requirements
- R1: `in_ready` is low while the buffer holds WORDS accepted symbols (committed or not) that have not been read. No symbol is accepted in that state.
- R2: The n-th accepted symbol since the last rewind is written at address (n mod WORDS). The stored word is {in_ok, in_data}, with the flag in bit SYM_W.
- R3: While `play_en` is high, a read slot comes every RD_DIV cycles. Each slot gives one `out_valid` pulse in the following cycle, so pulses are exactly RD_DIV cycles apart.
- R4: `fill_level` counts committed symbols not yet read. A frame of FRAME_SYMS symbols is committed only after its last symbol reaches memory, so a partial frame adds nothing to the fill and is never read.
- R5: A read and a pending write that fall in the same cycle are resolved in favour of the read. The held write goes out in a later free cycle, so every accepted symbol is eventually written exactly once.
- R6: While `shock` is high, `in_ready` is low and the write pointer returns to the last committed frame boundary. The next accepted symbol is written at that boundary address.
- R7: A read slot that finds `fill_level` zero produces an `out_valid` pulse with `out_data` zero and `out_ok` low. It also sets `underflow`, which stays high until reset.
- R8: `spd_up` is 1 after reset. It clears one cycle after `fill_level` is at least HIGH_FRAMES*FRAME_SYMS, sets one cycle after `fill_level` drops below LOW_FRAMES*FRAME_SYMS, and otherwise keeps its value.
- R9: Directly after reset: `in_ready`=1, `out_valid`=0, `mem_en`=0, `fill_level`=0, `underflow`=0, `spd_up`=1.
- R10: Valid reads return the committed symbols in the order they were accepted, with each symbol's data and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Controller can take the symbol |
| in_data | input | SYM_W | Raw symbol |
| in_ok | input | 1 | Validity flag of the symbol |
| shock | input | 1 | Shock in progress: pause and rewind writes |
| play_en | input | 1 | Enables the fixed-rate read slots |
| out_valid | output | 1 | One-cycle output symbol strobe |
| out_data | output | SYM_W | Output symbol (zero when muted) |
| out_ok | output | 1 | Output validity flag (low when muted) |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | log2(WORDS) | Memory word address |
| mem_wdata | output | SYM_W+1 | Write word {flag, symbol} |
| mem_rdata | input | SYM_W+1 | Read word, valid one cycle after a read |
| fill_level | output | log2(WORDS)+1 | Committed symbols not yet read |
| spd_up | output | 1 | Request above-normal disc speed |
| underflow | output | 1 | Sticky: a read slot found the buffer empty |

## Verification
The bench builds the block with 4-symbol frames, a 4-frame (16-word) buffer, a read slot every 3 cycles and speed marks at 1 and 3 frames. With these values the pointers wrap many times within a few thousand cycles. Filling the buffer to capacity takes only 16 symbols, and a drain reaches underflow quickly. The small frame also puts shock rewinds, partial frames and hysteresis crossings inside short directed sequences. The random phase feeds symbols faster than the read rate, so reads and held writes collide in many different phase alignments.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/sbc_wr_ctl.sv
module sbc_wr_ctl #(
  parameter int WORDS      = 256,
  parameter int FRAME_SYMS = 32,
  parameter int WW         = 9,
  localparam int AW        = $clog2(WORDS),
  localparam int PW        = AW + 1,
  localparam int FW        = $clog2(FRAME_SYMS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [WW-1:0] in_word,
  input  logic          shock,
  input  logic [PW-1:0] rd_ptr,
  input  logic          wr_grant,
  output logic          in_ready,
  output logic          hold_valid,
  output logic [AW-1:0] hold_addr,
  output logic [WW-1:0] hold_word,
  output logic [PW-1:0] commit_ptr
);
  logic [PW-1:0] wr_ptr, hold_ptr_q, commit_q, used;
  logic [WW-1:0] hold_word_q;
  logic          hold_valid_q, room, accept, hold_last;

  assign used      = wr_ptr - rd_ptr;
  assign room      = used < PW'(WORDS);
  assign in_ready  = !shock && room && (!hold_valid_q || wr_grant);
  assign accept    = in_valid && in_ready;
  assign hold_last = &hold_ptr_q[FW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr       <= '0;
      hold_ptr_q   <= '0;
      commit_q     <= '0;
      hold_word_q  <= '0;
      hold_valid_q <= 1'b0;
    end else begin
      if (shock) begin
        wr_ptr       <= commit_q;
        hold_valid_q <= 1'b0;
      end else if (accept) begin
        hold_valid_q <= 1'b1;
        hold_ptr_q   <= wr_ptr;
        hold_word_q  <= in_word;
        wr_ptr       <= wr_ptr + 1'b1;
      end else if (wr_grant) begin
        hold_valid_q <= 1'b0;
      end
      if (wr_grant && hold_last) commit_q <= hold_ptr_q + 1'b1;
    end
  end

  assign hold_valid = hold_valid_q;
  assign hold_addr  = hold_ptr_q[AW-1:0];
  assign hold_word  = hold_word_q;
  assign commit_ptr = commit_q;
endmodule

// File: rtl/sbc_rd_ctl.sv
module sbc_rd_ctl #(
  parameter int SYM_W  = 8,
  parameter int PW     = 9,
  parameter int RD_DIV = 4,
  localparam int WW    = SYM_W + 1,
  localparam int CW    = (RD_DIV > 2) ? $clog2(RD_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             play_en,
  input  logic [PW-1:0]    commit_ptr,
  input  logic [WW-1:0]    mem_rdata,
  output logic             rd_go,
  output logic [PW-1:0]    rd_ptr,
  output logic [PW-1:0]    fill,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             out_ok,
  output logic             underflow
);
  logic [CW-1:0] cnt;
  logic [PW-1:0] rd_ptr_q;
  logic          slot, hit_q, out_valid_q, under_q;

  assign fill  = commit_ptr - rd_ptr_q;
  assign slot  = play_en && (cnt == '0);
  assign rd_go = slot && (fill != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      rd_ptr_q    <= '0;
      hit_q       <= 1'b0;
      out_valid_q <= 1'b0;
      under_q     <= 1'b0;
    end else begin
      cnt         <= (cnt == CW'(RD_DIV - 1)) ? '0 : cnt + 1'b1;
      out_valid_q <= slot;
      hit_q       <= rd_go;
      if (rd_go) rd_ptr_q <= rd_ptr_q + 1'b1;
      if (slot && fill == '0) under_q <= 1'b1;
    end
  end

  assign rd_ptr    = rd_ptr_q;
  assign out_valid = out_valid_q;
  assign out_data  = hit_q ? mem_rdata[SYM_W-1:0] : '0;
  assign out_ok    = hit_q & mem_rdata[SYM_W];
  assign underflow = under_q;
endmodule

// File: rtl/sbc_arbiter.sv
module sbc_arbiter #(
  parameter int AW = 8,
  parameter int WW = 9
) (
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  input  logic          hold_valid,
  input  logic [AW-1:0] hold_addr,
  input  logic [WW-1:0] hold_word,
  input  logic          shock,
  output logic          wr_grant,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [WW-1:0] mem_wdata
);
  import sbc_pkg::*;
  acc_kind_e kind;

  always_comb begin
    kind = ACC_NONE;
    if (rd_go)                      kind = ACC_READ;
    else if (hold_valid && !shock)  kind = ACC_WRITE;
  end

  assign wr_grant  = (kind == ACC_WRITE);
  assign mem_en    = (kind != ACC_NONE);
  assign mem_we    = (kind == ACC_WRITE);
  assign mem_addr  = (kind == ACC_READ) ? rd_addr : hold_addr;
  assign mem_wdata = hold_word;
endmodule

// File: rtl/sbc_speed.sv
module sbc_speed #(
  parameter int PW        = 9,
  parameter int LOW_SYMS  = 64,
  parameter int HIGH_SYMS = 192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] fill,
  output logic          spd_up
);
  always_ff @(posedge clk) begin
    if (!rst_n)                       spd_up <= 1'b1;
    else if (fill >= PW'(HIGH_SYMS))  spd_up <= 1'b0;
    else if (fill <  PW'(LOW_SYMS))   spd_up <= 1'b1;
  end
endmodule

// File: rtl/shock_buf_ctrl.sv
module shock_buf_ctrl #(
  parameter int SYM_W        = 8,
  parameter int FRAME_SYMS   = 32,
  parameter int DEPTH_FRAMES = 8,
  parameter int RD_DIV       = 4,
  parameter int LOW_FRAMES   = 2,
  parameter int HIGH_FRAMES  = 6,
  localparam int WORDS       = FRAME_SYMS * DEPTH_FRAMES,
  localparam int AW          = $clog2(WORDS),
  localparam int PW          = AW + 1,
  localparam int WW          = SYM_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_ok,
  input  logic             shock,
  input  logic             play_en,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             out_ok,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [WW-1:0]    mem_wdata,
  input  logic [WW-1:0]    mem_rdata,
  output logic [PW-1:0]    fill_level,
  output logic             spd_up,
  output logic             underflow
);
  logic          wr_grant, hold_valid, rd_go;
  logic [AW-1:0] hold_addr;
  logic [WW-1:0] hold_word;
  logic [PW-1:0] commit_ptr, rd_ptr, fill;

  sbc_wr_ctl #(.WORDS(WORDS), .FRAME_SYMS(FRAME_SYMS), .WW(WW)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word({in_ok, in_data}),
    .shock(shock), .rd_ptr(rd_ptr), .wr_grant(wr_grant), .in_ready(in_ready),
    .hold_valid(hold_valid), .hold_addr(hold_addr), .hold_word(hold_word),
    .commit_ptr(commit_ptr)
  );

  sbc_rd_ctl #(.SYM_W(SYM_W), .PW(PW), .RD_DIV(RD_DIV)) u_rd (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .commit_ptr(commit_ptr),
    .mem_rdata(mem_rdata), .rd_go(rd_go), .rd_ptr(rd_ptr), .fill(fill),
    .out_valid(out_valid), .out_data(out_data), .out_ok(out_ok),
    .underflow(underflow)
  );

  sbc_arbiter #(.AW(AW), .WW(WW)) u_arb (
    .rd_go(rd_go), .rd_addr(rd_ptr[AW-1:0]), .hold_valid(hold_valid),
    .hold_addr(hold_addr), .hold_word(hold_word), .shock(shock),
    .wr_grant(wr_grant), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  sbc_speed #(.PW(PW), .LOW_SYMS(LOW_FRAMES * FRAME_SYMS),
              .HIGH_SYMS(HIGH_FRAMES * FRAME_SYMS)) u_spd (
    .clk(clk), .rst_n(rst_n), .fill(fill), .spd_up(spd_up)
  );

  assign fill_level = fill;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int SYM_W     = 8,
  parameter int PW        = 9,
  parameter int WORDS     = 256,
  parameter int LOW_SYMS  = 64,
  parameter int HIGH_SYMS = 192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             shock,
  input logic             out_valid,
  input logic [SYM_W-1:0] out_data,
  input logic             out_ok,
  input logic             mem_en,
  input logic             mem_we,
  input logic [PW-1:0]    fill_level,
  input logic             spd_up,
  input logic             underflow
);
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= PW'(WORDS));

  assert_read_gives_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> out_valid);

  assert_out_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_no_accept_in_shock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shock |-> !in_ready);

  assert_mute_on_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fill_level) == '0) |-> (out_data == '0 && !out_ok));

  assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  assert_spd_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level >= PW'(HIGH_SYMS)) |=> !spd_up);

  assert_spd_engage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level < PW'(LOW_SYMS)) |=> spd_up);
endmodule

bind shock_buf_ctrl sbc_checker #(
  .SYM_W(SYM_W), .PW(PW), .WORDS(WORDS),
  .LOW_SYMS(LOW_FRAMES * FRAME_SYMS), .HIGH_SYMS(HIGH_FRAMES * FRAME_SYMS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .shock(shock),
  .out_valid(out_valid), .out_data(out_data), .out_ok(out_ok),
  .mem_en(mem_en), .mem_we(mem_we), .fill_level(fill_level),
  .spd_up(spd_up), .underflow(underflow)
);

// File: tb/shock_buf_ctrl_tb_top.sv
module shock_buf_ctrl_tb_top;
  localparam int SYM_W = 8, FS = 4, DF = 4, RD_DIV = 3, LOWF = 1, HIGHF = 3;
  localparam int WORDS = FS * DF, AW = $clog2(WORDS), PW = AW + 1, WW = SYM_W + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ok = 1'b0, shock = 1'b0, play_en = 1'b0;
  logic [SYM_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_ok, mem_en, mem_we, spd_up, underflow;
  logic [SYM_W-1:0] out_data;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata, mem_rdata;
  logic [PW-1:0] fill_level;

  always #4 clk = ~clk;

  shock_buf_ctrl #(.SYM_W(SYM_W), .FRAME_SYMS(FS), .DEPTH_FRAMES(DF), .RD_DIV(RD_DIV),
                   .LOW_FRAMES(LOWF), .HIGH_FRAMES(HIGHF)) dut_i (.*);

  logic [WW-1:0] mem [WORDS];
  always @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
  end

  int checks = 0, fails = 0, cyc = 0;
  int accepted = 0, writes = 0, wr_idx = 0, commit_idx = 0;
  int last_out = -1, play_run = 0;
  bit after_shock = 0;
  logic [WW-1:0] partial[$], expq[$], wword_q[$];
  int waddr_q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit spd_model(bit prev, int fill);
    if (fill >= HIGHF * FS) return 1'b0;
    if (fill < LOWF * FS) return 1'b1;
    return prev;
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Scoreboard, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (shock) begin
        partial.delete();
        wr_idx = commit_idx;
        after_shock = 1;
      end
      if (in_valid && in_ready) begin
        partial.push_back({in_ok, in_data});
        waddr_q.push_back(wr_idx % WORDS);
        wword_q.push_back({in_ok, in_data});
        wr_idx++; accepted++;
        if (partial.size() == FS) begin
          foreach (partial[k]) expq.push_back(partial[k]);
          partial.delete();
          commit_idx = wr_idx;
        end
      end
      if (mem_en && mem_we) begin
        writes++;
        if (waddr_q.size() == 0) chk(0, "R5", "unexpected write", 1, 0);
        else begin
          int a; logic [WW-1:0] w;
          a = waddr_q.pop_front(); w = wword_q.pop_front();
          if (after_shock) chk(int'(mem_addr) == a, "R6", "write address after rewind", mem_addr, a);
          else chk(int'(mem_addr) == a, "R2", "write address", mem_addr, a);
          chk(mem_wdata == w, "R2", "write word", mem_wdata, w);
          after_shock = 0;
        end
      end
      if (out_valid) begin
        if (play_run > RD_DIV + 1 && last_out >= 0)
          chk(cyc - last_out == RD_DIV, "R3", "read strobe spacing", cyc - last_out, RD_DIV);
        last_out = cyc;
        if (expq.size() == 0) begin
          chk(out_data == '0 && !out_ok, "R7", "muted symbol", {out_ok, out_data}, 0);
        end else begin
          logic [WW-1:0] e;
          e = expq.pop_front();
          chk({out_ok, out_data} == e, "R10", "output symbol", {out_ok, out_data}, e);
        end
      end
      play_run = play_en ? play_run + 1 : 0;
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R3 watchdog: actual %0d cycles expected completion", cyc);
      finish_up();
    end
  end

  task automatic push_sym(logic [SYM_W-1:0] d, logic ok);
    in_data = d; in_ok = ok; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0 && mem_en == 1'b0, "R9", "idle outputs after reset", {out_valid, mem_en}, 0);
    chk(fill_level == '0, "R9", "fill after reset", fill_level, 0);
    chk(underflow == 1'b0, "R9", "underflow after reset", underflow, 0);
    chk(spd_up == 1'b1, "R9", "spd_up after reset", spd_up, 1);
    idle(1);

    // R4: partial frame adds nothing
    for (int i = 0; i < FS - 1; i++) push_sym(8'h10 + 8'(i), 1'b1);
    idle(3); @(negedge clk);
    chk(fill_level == '0, "R4", "fill with partial frame", fill_level, 0);
    idle(1);
    push_sym(8'h1F, 1'b0);
    idle(3); @(negedge clk);
    chk(fill_level == PW'(FS), "R4", "fill after one frame", fill_level, FS);
    chk(spd_up == spd_model(1'b1, FS), "R8", "spd held between marks", spd_up, 1);
    idle(1);
    for (int i = 0; i < 2 * FS; i++) push_sym(8'h20 + 8'(i), 1'(i % 3 != 0));
    idle(3); @(negedge clk);
    chk(fill_level == PW'(3 * FS), "R4", "fill after three frames", fill_level, 3 * FS);
    chk(spd_up == spd_model(1'b1, 3 * FS), "R8", "spd released at high mark", spd_up, 0);
    idle(1);

    // R1: fill to capacity, then hold in_valid
    for (int i = 0; i < FS; i++) push_sym(8'h40 + 8'(i), 1'b1);
    idle(3); @(negedge clk);
    chk(in_ready == 1'b0, "R1", "in_ready when full", in_ready, 0);
    chk(fill_level == PW'(WORDS), "R1", "fill when full", fill_level, WORDS);
    idle(1);
    in_data = 8'hEE; in_valid = 1'b1;
    idle(5);
    in_valid = 1'b0;
    @(negedge clk);
    chk(accepted == WORDS, "R1", "symbols accepted while full", accepted, WORDS);
    idle(1);

    // Random phase with a directed shock in the middle
    play_en = 1'b1;
    for (int i = 0; i < 2500; i++) begin
      if (i == 1200) begin
        idle(3);
        push_sym(8'hA1, 1'b1);
        push_sym(8'hA2, 1'b1);
        idle(3);
        shock = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R6", "in_ready during shock", in_ready, 0);
        idle(3);
        shock = 1'b0;
      end
      if ($urandom % 10 < 6) push_sym(8'($urandom), 1'($urandom % 4 != 0));
      else idle(1);
    end
    @(negedge clk);
    chk(underflow == 1'b0, "R7", "no underflow while fed", underflow, 0);
    idle(1);

    // Drain to underflow
    idle(WORDS * RD_DIV * 3);
    @(negedge clk);
    chk(underflow == 1'b1, "R7", "underflow after drain", underflow, 1);
    chk(spd_up == 1'b1, "R8", "spd engaged when empty", spd_up, 1);
    chk(fill_level == '0, "R4", "fill after drain", fill_level, 0);
    chk(writes == accepted, "R5", "all accepted symbols written", writes, accepted);
    chk(expq.size() == 0, "R10", "unread committed symbols", expq.size(), 0);
    play_en = 1'b0;
    idle(2);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(underflow == 1'b0, "R7", "underflow cleared by reset", underflow, 0);
    finish_up();
  end
endmodule